// File: doc/BRIEF.md
# Two-Pipe Four-Layer Pixel Compositor

This block produces one output colour per screen position from four image layers. Every cycle it receives the current screen coordinate and one 32-bit pixel per layer, with alpha in the top byte. Each layer carries its own placement rectangle, enable, 2-bit priority, pipe assignment bit and an optional 8-bit global alpha. Composition runs in two steps. First, each of the two pipes picks a single layer among those that are assigned to it and cover the coordinate. No blending happens inside a pipe. Second, the pipe 0 pixel is laid over a background colour using its alpha, and the pipe 1 pixel is then laid over that result using its own alpha.

A compatibility switch reproduces a known defect of this two-step scheme. A translucent pixel from the lowest-priority layer of pipe 0 is thrown away, and the background shows through in its place. The result leaves the block two clock cycles after the coordinate and layer data are presented. A valid flag travels alongside the data. A typical setting of the background input is black.

Top module: `two_pipe_compositor`

## Requirements
- R1: A layer covers the screen position (x, y) only if it is enabled, lx <= x < lx+w and ly <= y < ly+h. A disabled layer, or one with zero width or height, covers nothing.
- R2: Within one pipe, the covering layer with the numerically largest priority wins outright, with no blending. When two covering layers tie on priority, the one with the lower layer index wins.
- R3: Pixel layout is alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0. The effective alpha is floor(pa*ga/255) when the layer's global-alpha enable is set, and pa otherwise.
- R4: The pipe 0 winner is mixed over the background with its effective alpha. If no pipe 0 layer covers the position, the pipe 0 result is the background colour.
- R5: Each channel is mixed as (a*top + (255-a)*bottom + 127)/255 with integer division. The pipe 1 winner is mixed over the pipe 0 result in this way. If no pipe 1 layer covers the position, the pipe 0 result passes unchanged.
- R6: When the quirk switch is 1 and the pipe 0 winner has priority 0 and an effective alpha below 255, the pipe 0 result is the background colour. When the switch is 0, the winner is mixed normally.
- R7: out_valid and out_rgb reflect the inputs presented two rising clock edges earlier.
- R8: While reset is asserted, out_valid is 0 and out_rgb is 0.
- R9: The pipe select bit places a layer in pipe 0 (bit 0) or pipe 1 (bit 1). A pipe 1 pixel always lies above the pipe 0 pixel, whatever the two priorities are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the current coordinate as a real pixel |
| scr_x | input | CW | Screen column |
| scr_y | input | CW | Screen row |
| lay_en | input | NUM_LAYERS | Per-layer enable |
| lay_x | input | NUM_LAYERS*CW | Per-layer left edge, layer i in slice i |
| lay_y | input | NUM_LAYERS*CW | Per-layer top edge |
| lay_w | input | NUM_LAYERS*CW | Per-layer width |
| lay_h | input | NUM_LAYERS*CW | Per-layer height |
| lay_prio | input | NUM_LAYERS*PRIO_W | Per-layer priority |
| lay_pipe | input | NUM_LAYERS | Per-layer pipe select |
| lay_galpha | input | NUM_LAYERS*8 | Per-layer global alpha |
| lay_galpha_en | input | NUM_LAYERS | Per-layer global-alpha enable |
| lay_pix | input | NUM_LAYERS*32 | Per-layer ARGB pixel at this position |
| bg_color | input | 24 | Background colour, RGB |
| quirk_en | input | 1 | Enables the lowest-layer drop behaviour |
| out_valid | output | 1 | in_valid delayed by two cycles |
| out_rgb | output | 24 | Composited RGB pixel |

## Verification
The drop of a translucent lowest pipe 0 layer (R6) and the mixing of a translucent pipe 1 layer (R5) can happen on the same pixel. In that case, pipe 1 must be mixed over the background and not over the dropped pixel. Directed steps build exactly this stack, once with the switch on and once with it off. The randomised phase also toggles the switch while layers overlap in both pipes. On every clock, the output is judged against the reference value computed two cycles earlier from the stimulus alone.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int NUM_PIPES = 2;
    localparam int CH_W      = 8;
    localparam int PIX_W     = 32;
    localparam int RGB_W     = 24;

    // One colour channel: (a*top + (255-a)*bot + 127) / 255
    function automatic logic [CH_W-1:0] mix8(input logic [7:0] a,
                                             input logic [7:0] top,
                                             input logic [7:0] bot);
        logic [16:0] acc;
        acc = 17'(a) * 17'(top) + 17'(8'hFF - a) * 17'(bot) + 17'd127;
        return 8'(acc / 17'd255);
    endfunction

    function automatic logic [RGB_W-1:0] mix_rgb(input logic [7:0]       a,
                                                 input logic [RGB_W-1:0] top,
                                                 input logic [RGB_W-1:0] bot);
        logic [RGB_W-1:0] res;
        for (int c = 0; c < 3; c++)
            res[c*CH_W +: CH_W] = mix8(a, top[c*CH_W +: CH_W], bot[c*CH_W +: CH_W]);
        return res;
    endfunction

    function automatic logic [7:0] scale_alpha(input logic [7:0] pa,
                                               input logic [7:0] ga,
                                               input logic       use_ga);
        return use_ga ? 8'((16'(pa) * 16'(ga)) / 16'd255) : pa;
    endfunction

endpackage

// File: rtl/cmp_layer_cover.sv
module cmp_layer_cover
    import cmp_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic             en,
    input  logic [CW-1:0]    sx,
    input  logic [CW-1:0]    sy,
    input  logic [CW-1:0]    x0,
    input  logic [CW-1:0]    y0,
    input  logic [CW-1:0]    w,
    input  logic [CW-1:0]    h,
    input  logic [7:0]       pix_alpha,
    input  logic [7:0]       galpha,
    input  logic             galpha_en,
    output logic             hit,
    output logic [7:0]       eff_alpha
);
    localparam int EW = CW + 1;

    logic in_x, in_y;

    always_comb begin
        in_x      = (EW'(sx) >= EW'(x0)) && (EW'(sx) < EW'(x0) + EW'(w));
        in_y      = (EW'(sy) >= EW'(y0)) && (EW'(sy) < EW'(y0) + EW'(h));
        hit       = en && in_x && in_y;
        eff_alpha = scale_alpha(pix_alpha, galpha, galpha_en);
    end
endmodule

// File: rtl/cmp_pipe_pick.sv
module cmp_pipe_pick #(
    parameter int NL      = 4,
    parameter int PRIO_W  = 2,
    parameter int PIPE_ID = 0
) (
    input  logic [NL-1:0]        hit,
    input  logic [NL-1:0]        pipe_sel,
    input  logic [NL*PRIO_W-1:0] prio,
    output logic [NL-1:0]        grant
);
    logic              found;
    logic [PRIO_W-1:0] best;

    always_comb begin
        grant = '0;
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < NL; i++) begin
            if (hit[i] && (pipe_sel[i] == 1'(PIPE_ID))) begin
                // strictly greater keeps the lower index on a tie
                if (!found || (prio[i*PRIO_W +: PRIO_W] > best)) begin
                    grant = '0;
                    grant[i] = 1'b1;
                    best  = prio[i*PRIO_W +: PRIO_W];
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/two_pipe_compositor.sv
module two_pipe_compositor
    import cmp_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int CW         = 12,
    parameter int PRIO_W     = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [CW-1:0]                scr_x,
    input  logic [CW-1:0]                scr_y,
    input  logic [NUM_LAYERS-1:0]        lay_en,
    input  logic [NUM_LAYERS*CW-1:0]     lay_x,
    input  logic [NUM_LAYERS*CW-1:0]     lay_y,
    input  logic [NUM_LAYERS*CW-1:0]     lay_w,
    input  logic [NUM_LAYERS*CW-1:0]     lay_h,
    input  logic [NUM_LAYERS*PRIO_W-1:0] lay_prio,
    input  logic [NUM_LAYERS-1:0]        lay_pipe,
    input  logic [NUM_LAYERS*8-1:0]      lay_galpha,
    input  logic [NUM_LAYERS-1:0]        lay_galpha_en,
    input  logic [NUM_LAYERS*32-1:0]     lay_pix,
    input  logic [23:0]                  bg_color,
    input  logic                         quirk_en,
    output logic                         out_valid,
    output logic [23:0]                  out_rgb
);
    logic [NUM_LAYERS-1:0] hit;
    logic [7:0]            eff_a [NUM_LAYERS];
    logic [NUM_LAYERS-1:0] grant [NUM_PIPES];

    genvar g;
    generate
        for (g = 0; g < NUM_LAYERS; g++) begin : g_layer
            cmp_layer_cover #(.CW(CW)) u_cover (
                .en        (lay_en[g]),
                .sx        (scr_x),
                .sy        (scr_y),
                .x0        (lay_x[g*CW +: CW]),
                .y0        (lay_y[g*CW +: CW]),
                .w         (lay_w[g*CW +: CW]),
                .h         (lay_h[g*CW +: CW]),
                .pix_alpha (lay_pix[g*PIX_W+24 +: 8]),
                .galpha    (lay_galpha[g*8 +: 8]),
                .galpha_en (lay_galpha_en[g]),
                .hit       (hit[g]),
                .eff_alpha (eff_a[g])
            );
        end
        for (g = 0; g < NUM_PIPES; g++) begin : g_pipe
            cmp_pipe_pick #(.NL(NUM_LAYERS), .PRIO_W(PRIO_W), .PIPE_ID(g)) u_pick (
                .hit      (hit),
                .pipe_sel (lay_pipe),
                .prio     (lay_prio),
                .grant    (grant[g])
            );
        end
    endgenerate

    // winner of each pipe
    logic [NUM_PIPES-1:0] win_hit;
    logic [RGB_W-1:0]     win_rgb  [NUM_PIPES];
    logic [7:0]           win_a    [NUM_PIPES];
    logic [PRIO_W-1:0]    win_prio [NUM_PIPES];

    always_comb begin
        for (int p = 0; p < NUM_PIPES; p++) begin
            win_hit[p]  = |grant[p];
            win_rgb[p]  = '0;
            win_a[p]    = '0;
            win_prio[p] = '0;
            for (int i = 0; i < NUM_LAYERS; i++) begin
                if (grant[p][i]) begin
                    win_rgb[p]  = lay_pix[i*PIX_W +: RGB_W];
                    win_a[p]    = eff_a[i];
                    win_prio[p] = lay_prio[i*PRIO_W +: PRIO_W];
                end
            end
        end
    end

    // first step: pipe 0 over background, with optional drop
    logic             p0_drop;
    logic [RGB_W-1:0] base_d;

    always_comb begin
        p0_drop = quirk_en && win_hit[0] && (win_prio[0] == '0) && (win_a[0] != 8'hFF);
        if (win_hit[0] && !p0_drop)
            base_d = mix_rgb(win_a[0], win_rgb[0], bg_color);
        else
            base_d = bg_color;
    end

    logic             s1_valid;
    logic [RGB_W-1:0] s1_base;
    logic             s1_p1_hit;
    logic [RGB_W-1:0] s1_p1_rgb;
    logic [7:0]       s1_p1_a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_base   <= '0;
            s1_p1_hit <= 1'b0;
            s1_p1_rgb <= '0;
            s1_p1_a   <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_base   <= base_d;
            s1_p1_hit <= win_hit[1];
            s1_p1_rgb <= win_rgb[1];
            s1_p1_a   <= win_a[1];
        end
    end

    // second step: pipe 1 over the first-step result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_rgb   <= s1_p1_hit ? mix_rgb(s1_p1_a, s1_p1_rgb, s1_base) : s1_base;
        end
    end
endmodule

// File: rtl/cmp_checker.sv
module cmp_checker #(
    parameter int NL = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [23:0]   out_rgb,
    input logic [NL-1:0] lay_en,
    input logic [NL-1:0] grant0,
    input logic [NL-1:0] grant1,
    input logic          p0_hit,
    input logic          p0_drop,
    input logic [23:0]   bg_color,
    input logic          s1_p1_hit,
    input logic [23:0]   s1_base
);
    logic [1:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since <= '0;
        else if (since != 2'd3)
            since <= since + 2'd1;
    end

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_rgb == 24'd0));

    // R2
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant0) && $onehot0(grant1) && ((grant0 & grant1) == '0));

    // R1
    grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant0 | grant1) & ~lay_en) == '0);

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_p1_hit |=> (out_rgb == $past(s1_base)));

    // R6
    quirk_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p0_drop |=> (s1_base == $past(bg_color)));

    // R4
    empty_pipe0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_hit |=> (s1_base == $past(bg_color)));
endmodule

bind two_pipe_compositor cmp_checker #(.NL(NUM_LAYERS)) u_cmp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .lay_en    (lay_en),
    .grant0    (grant[0]),
    .grant1    (grant[1]),
    .p0_hit    (win_hit[0]),
    .p0_drop   (p0_drop),
    .bg_color  (bg_color),
    .s1_p1_hit (s1_p1_hit),
    .s1_base   (s1_base)
);

// File: tb/test_two_pipe_compositor.sv
module test_two_pipe_compositor;
    localparam int NL = 4;
    localparam int CW = 12;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    always #5 clk = ~clk;

    logic          in_valid;
    logic [CW-1:0] sx, sy;
    logic          en  [NL];
    logic [CW-1:0] lx  [NL];
    logic [CW-1:0] ly  [NL];
    logic [CW-1:0] lw  [NL];
    logic [CW-1:0] lh  [NL];
    logic [PW-1:0] pr  [NL];
    logic          pp  [NL];
    logic [7:0]    ga  [NL];
    logic          gae [NL];
    logic [31:0]   px  [NL];
    logic [23:0]   bg;
    logic          qk;

    logic [NL-1:0]    v_en, v_pipe, v_gae;
    logic [NL*CW-1:0] v_x, v_y, v_w, v_h;
    logic [NL*PW-1:0] v_pr;
    logic [NL*8-1:0]  v_ga;
    logic [NL*32-1:0] v_px;
    logic             out_valid;
    logic [23:0]      out_rgb;

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            v_en[i]           = en[i];
            v_pipe[i]         = pp[i];
            v_gae[i]          = gae[i];
            v_x[i*CW +: CW]   = lx[i];
            v_y[i*CW +: CW]   = ly[i];
            v_w[i*CW +: CW]   = lw[i];
            v_h[i*CW +: CW]   = lh[i];
            v_pr[i*PW +: PW]  = pr[i];
            v_ga[i*8 +: 8]    = ga[i];
            v_px[i*32 +: 32]  = px[i];
        end
    end

    two_pipe_compositor #(.NUM_LAYERS(NL), .CW(CW), .PRIO_W(PW)) i_two_pipe_compositor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scr_x(sx), .scr_y(sy),
        .lay_en(v_en), .lay_x(v_x), .lay_y(v_y), .lay_w(v_w), .lay_h(v_h),
        .lay_prio(v_pr), .lay_pipe(v_pipe), .lay_galpha(v_ga), .lay_galpha_en(v_gae),
        .lay_pix(v_px), .bg_color(bg), .quirk_en(qk),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    logic [23:0] exp_rgb_q [$];
    logic        exp_v_q   [$];
    string       tag_q     [$];

    // ---------------- reference model ----------------
    function automatic int mixc(int a, int t, int b);
        return (a * t + (255 - a) * b + 127) / 255;
    endfunction

    function automatic logic [23:0] mix3(int a, logic [23:0] t, logic [23:0] b);
        logic [23:0] r;
        for (int c = 0; c < 3; c++)
            r[c*8 +: 8] = 8'(mixc(a, int'(t[c*8 +: 8]), int'(b[c*8 +: 8])));
        return r;
    endfunction

    function automatic int eff(int i);
        int pa;
        pa = int'(px[i][31:24]);
        return gae[i] ? (pa * int'(ga[i])) / 255 : pa;
    endfunction

    function automatic bit covers(int i);
        return en[i] && int'(sx) >= int'(lx[i]) && int'(sx) < int'(lx[i]) + int'(lw[i])
                     && int'(sy) >= int'(ly[i]) && int'(sy) < int'(ly[i]) + int'(lh[i]);
    endfunction

    function automatic int pick(int p);
        int best;
        best = -1;
        for (int i = 0; i < NL; i++)
            if (covers(i) && int'(pp[i]) == p && (best < 0 || pr[i] > pr[best]))
                best = i;
        return best;
    endfunction

    function automatic logic [23:0] model();
        int b0, b1;
        logic [23:0] res;
        b0 = pick(0);
        b1 = pick(1);
        res = bg;
        if (b0 >= 0 && !(qk && pr[b0] == 0 && eff(b0) < 255))
            res = mix3(eff(b0), px[b0][23:0], bg);
        if (b1 >= 0)
            res = mix3(eff(b1), px[b1][23:0], res);
        return res;
    endfunction

    // ---------------- stimulus helpers ----------------
    task automatic clear_layers();
        for (int i = 0; i < NL; i++) begin
            en[i] = 0; lx[i] = 0; ly[i] = 0; lw[i] = 0; lh[i] = 0;
            pr[i] = 0; pp[i] = 0; ga[i] = 8'hFF; gae[i] = 0; px[i] = 0;
        end
    endtask

    task automatic set_layer(int i, int x, int y, int w, int h, int p, int pipe,
                             int g, bit ge, logic [31:0] pix);
        en[i] = 1; lx[i] = CW'(x); ly[i] = CW'(y); lw[i] = CW'(w); lh[i] = CW'(h);
        pr[i] = PW'(p); pp[i] = pipe[0]; ga[i] = 8'(g); gae[i] = ge; px[i] = pix;
    endtask

    task automatic check_out(string t, logic ev, logic [23:0] er);
        total++;
        if (out_valid !== ev || out_rgb !== er) begin
            fails++;
            $display("FAIL %s: got valid=%0b rgb=%06h, expected valid=%0b rgb=%06h",
                     t, out_valid, out_rgb, ev, er);
        end
    endtask

    // present the current stimulus for one cycle; judge the output due now
    task automatic apply(string t);
        exp_rgb_q.push_back(model());
        exp_v_q.push_back(in_valid);
        tag_q.push_back(t);
        @(negedge clk);
        if (exp_rgb_q.size() >= 2) begin
            check_out(tag_q.pop_front(), exp_v_q.pop_front(), exp_rgb_q.pop_front());
        end
    endtask

    task automatic at_xy(string t, int x, int y);
        sx = CW'(x); sy = CW'(y); in_valid = 1;
        apply(t);
    endtask

    task automatic flush();
        in_valid = 0;
        apply("flush");
        apply("flush");
        exp_rgb_q.delete(); exp_v_q.delete(); tag_q.delete();
    endtask

    task automatic do_reset(string t);
        @(negedge clk);
        in_valid = 0;
        rst_n = 0;
        @(negedge clk);
        check_out(t, 1'b0, 24'h0);
        rst_n = 1;
        exp_rgb_q.delete(); exp_v_q.delete(); tag_q.delete();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            total++;
            fails++;
            $display("FAIL R7 watchdog: got cycle %0d, expected completion before 50000", cyc);
            finish_run();
        end
    end

    initial begin
        in_valid = 0; sx = 0; sy = 0; bg = 24'h000000; qk = 0;
        clear_layers();
        #2 rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        check_out("R8 reset state", 1'b0, 24'h0);
        rst_n = 1;
        @(negedge clk);

        // R1: rectangle edges, zero size, disabled layer
        bg = 24'h102030;
        set_layer(0, 4, 2, 3, 2, 0, 0, 255, 0, 32'hFF_C0_80_40);
        at_xy("R1 left outside", 3, 2);
        at_xy("R1 left edge", 4, 2);
        at_xy("R1 right inside", 6, 3);
        at_xy("R1 right outside", 7, 3);
        at_xy("R1 below", 5, 4);
        lw[0] = 0;
        at_xy("R1 zero width", 4, 2);
        lw[0] = 3; en[0] = 0;
        at_xy("R1 disabled", 5, 2);
        flush();

        // R2: priority inside pipe 0, then a tie
        clear_layers();
        set_layer(0, 0, 0, 8, 8, 1, 0, 255, 0, 32'hFF_11_22_33);
        set_layer(2, 0, 0, 8, 8, 2, 0, 255, 0, 32'h80_AA_BB_CC);
        at_xy("R2 higher priority wins", 1, 1);
        pr[0] = 2;
        at_xy("R2 tie lower index", 1, 1);
        pr[0] = 3;
        at_xy("R2 priority 3 wins", 2, 2);
        flush();

        // R3 and R4: effective alpha over background
        clear_layers();
        bg = 24'h204060;
        set_layer(1, 0, 0, 4, 4, 1, 0, 128, 1, 32'hC8_F0_10_80);
        at_xy("R3 global alpha on", 1, 1);
        gae[1] = 0;
        at_xy("R3 global alpha off", 1, 1);
        at_xy("R4 no pipe0 cover", 9, 9);
        px[1] = 32'h64_FF_FF_FF;
        at_xy("R4 pipe0 over background", 0, 0);
        flush();

        // R5 and R9: pipe 1 over pipe 0, independent of priority
        clear_layers();
        bg = 24'h000000;
        set_layer(0, 0, 0, 6, 6, 3, 0, 255, 0, 32'hFF_40_80_C0);
        set_layer(3, 2, 2, 6, 6, 0, 1, 255, 0, 32'h90_F0_20_10);
        at_xy("R5 pipe1 blended over pipe0", 3, 3);
        at_xy("R5 pipe1 absent passes pipe0", 1, 1);
        px[3] = 32'hFF_05_06_07;
        at_xy("R9 pipe1 above higher-prio pipe0", 4, 4);
        pp[3] = 0; pr[3] = 0;
        at_xy("R9 moved to pipe0 loses", 4, 4);
        flush();

        // R6: drop of a translucent lowest pipe 0 layer, with pipe 1 on top
        clear_layers();
        bg = 24'h0A0B0C;
        set_layer(0, 0, 0, 8, 8, 0, 0, 255, 0, 32'h80_FF_00_00);
        set_layer(1, 0, 0, 8, 8, 1, 1, 255, 0, 32'h40_00_FF_00);
        qk = 1;
        at_xy("R6 quirk drop with pipe1", 2, 2);
        qk = 0;
        at_xy("R6 quirk off mixes normally", 2, 2);
        qk = 1; px[0] = 32'hFF_FF_00_00;
        at_xy("R6 opaque layer not dropped", 2, 2);
        px[0] = 32'hFF_FF_00_00; gae[0] = 1; ga[0] = 8'd200;
        at_xy("R6 global alpha triggers drop", 2, 2);
        pr[0] = 1;
        at_xy("R6 priority 1 not dropped", 2, 2);
        qk = 0;
        flush();

        // R7: valid pattern
        for (int k = 0; k < 8; k++) begin
            sx = CW'(k); in_valid = k[0] ^ k[2];
            apply("R7 valid delay");
        end
        flush();

        // R8: reset mid-run
        clear_layers();
        set_layer(0, 0, 0, 8, 8, 0, 0, 255, 0, 32'hFF_FF_FF_FF);
        at_xy("R8 before reset", 1, 1);
        at_xy("R8 before reset", 1, 1);
        do_reset("R8 reset clears output");

        // random mix of everything
        for (int n = 0; n < 600; n++) begin
            for (int i = 0; i < NL; i++) begin
                en[i]  = ($urandom_range(0, 3) != 0);
                lx[i]  = CW'($urandom_range(0, 10));
                ly[i]  = CW'($urandom_range(0, 10));
                lw[i]  = CW'($urandom_range(0, 8));
                lh[i]  = CW'($urandom_range(0, 8));
                pr[i]  = PW'($urandom_range(0, 3));
                pp[i]  = 1'($urandom_range(0, 1));
                ga[i]  = 8'($urandom_range(0, 255));
                gae[i] = 1'($urandom_range(0, 1));
                px[i]  = $urandom();
                if ($urandom_range(0, 2) == 0) px[i][31:24] = 8'hFF;
            end
            bg = 24'($urandom());
            qk = 1'($urandom_range(0, 1));
            sx = CW'($urandom_range(0, 15));
            sy = CW'($urandom_range(0, 15));
            in_valid = 1'($urandom_range(0, 1));
            apply("random R1 R2 R3 R4 R5 R6 R9");
        end
        flush();

        finish_run();
    end
endmodule